// File: doc/BRIEF.md
# SerDes Lane Receive Override Sequencer

This block drives a per-lane receive override inside a SerDes through a
simple control-register master port (address, write data, read data, a
write-not-read flag, a one-cycle start strobe and a busy flag returned by the
register side). A single command selects one lane and one of two operations.
"Release" reads the lane status register and writes the same value, with the
override-enable bit cleared, into the lane override register. "Engage" first
polls the status register until the half-rate indication drops, or until a
read limit is reached, and then walks the override register through five
writes: enable cleared, enable set, loop-mode field set to 3, loop reset
raised, and loop reset dropped. It then waits a settle time.

A one-cycle `done` pulse marks the end of every command. The spacing between
register transactions and the settle time are cycle counts set by parameters.
At 50 MHz the defaults give about 25 us and 15 ms. A higher-level retry policy
issues the commands around a link reset.

Top module: `serdes_rx_ovr_seq`

## Requirements
- R1: The register address for lane L is the lane-0 address plus L*0x100. The lane-0 status address is 0x2002 and the lane-0 override address is 0x2005.
- R2: A release command (`cmd_op`=0) makes exactly one read of status. It then makes exactly one write of (status & ~0x4000) to the override register, and `done` follows.
- R3: An engage command (`cmd_op`=1) reads status again while bit 0 (half-rate) is 1. It stops after POLL_MAX reads in total and goes on to the writes in either case, using the last value read.
- R4: After polling, an engage command writes the override register five times, in this order, where B = last status & ~0x4000. The values are B; B|0x4000; (B|0x4000) with bits 10:8 set to 3; that value with bit 11 set; that value with bit 11 clear.
- R5: After the last engage write completes, `done` is held off for at least SETTLE_CYC cycles.
- R6: Two successive `cr_start` strobes are at least GAP_CYC cycles apart. A strobe is raised only when `cr_busy` was low on the cycle before it. `cr_wr` is 1 for a write and 0 for a read.
- R7: `done` and `cr_start` are single-cycle pulses, and `done` comes exactly once per accepted command.
- R8: A command that arrives while a command is in progress is ignored. Its lane and operation do not appear in any transaction, and it produces no extra `done`.
- R9: During and after reset, with no command, `cr_start` and `done` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 1 | 0 = release override, 1 = engage override |
| cmd_lane | input | LANE_W | Lane index |
| cr_addr | output | 16 | Control-register address |
| cr_wdata | output | 16 | Control-register write data |
| cr_rdata | input | 16 | Control-register read data, valid once busy is low |
| cr_wr | output | 1 | 1 = write, 0 = read |
| cr_start | output | 1 | One-cycle transaction strobe |
| cr_busy | input | 1 | Register side busy |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the register side lowers `cr_busy` within bounded time after each strobe. They also assume `cr_rdata` is valid by the time busy is low, and that `cmd_lane` is below LANES. The bench register model holds busy for three cycles after each strobe. That is shorter than the shortened gap count, and the model presents read data on the strobe edge. The bench issues only lane values inside the configured range, so every assumed input condition holds throughout the run.

// File: rtl/serdes_ovr_pkg.sv
package serdes_ovr_pkg;
  localparam logic [15:0] STAT_REG  = 16'h2002;
  localparam logic [15:0] OVR_REG   = 16'h2005;
  localparam logic [15:0] EN_BIT    = 16'h4000;
  localparam logic [15:0] MODE_FLD  = 16'h0700;
  localparam logic [15:0] MODE_SET  = 16'h0300;
  localparam logic [15:0] LRST_BIT  = 16'h0800;
  localparam int          WR_STEPS  = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_WRITE, S_SETTLE, S_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    X_IDLE, X_WRDY, X_ISSUE, X_GAP, X_FIN
  } xact_state_t;
endpackage

// File: rtl/dly_timer.sv
module dly_timer #(
  parameter int MAXV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(MAXV + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? CW'(MAXV) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cr_xact.sv
module cr_xact
  import serdes_ovr_pkg::*;
#(
  parameter int GAP_CYC = 1250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        req_wr,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        ack,
  output logic [15:0] rdata,
  output logic [15:0] cr_addr,
  output logic [15:0] cr_wdata,
  input  logic [15:0] cr_rdata,
  output logic        cr_wr,
  output logic        cr_start,
  input  logic        cr_busy
);
  localparam int GW = $clog2(GAP_CYC + 1);

  xact_state_t xs_q, xs_d;
  logic [15:0] addr_q, wdata_q;
  logic        wr_q, cap_en, gap_done;

  dly_timer #(.MAXV(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(xs_q == X_ISSUE), .expired(gap_done)
  );

  always_comb begin
    xs_d   = xs_q;
    cap_en = 1'b0;
    unique case (xs_q)
      X_IDLE:  if (req) begin xs_d = X_WRDY; cap_en = 1'b1; end
      X_WRDY:  if (!cr_busy) xs_d = X_ISSUE;
      X_ISSUE: xs_d = X_GAP;
      X_GAP:   if (gap_done) xs_d = X_FIN;
      X_FIN:   if (!cr_busy) xs_d = X_IDLE;
      default: xs_d = X_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xs_q <= X_IDLE;
    else        xs_q <= xs_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; wdata_q <= '0; wr_q <= 1'b0;
    end else if (cap_en) begin
      addr_q <= req_addr; wdata_q <= req_wdata; wr_q <= req_wr;
    end
  end

  assign cr_addr  = addr_q;
  assign cr_wdata = wdata_q;
  assign cr_wr    = wr_q;
  assign cr_start = (xs_q == X_ISSUE);
  assign ack      = (xs_q == X_FIN) && !cr_busy;
  assign rdata    = cr_rdata;

  // Independent spacing monitor for the strobe
  logic [GW-1:0] since_q;
  logic          seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0; seen_q <= 1'b0;
    end else if (cr_start) begin
      since_q <= '0; seen_q <= 1'b1;
    end else if (since_q != GW'(GAP_CYC)) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_start_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_start && seen_q) |-> (since_q >= GW'(GAP_CYC - 1)));
  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cr_start |=> !cr_start);
  p_start_after_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cr_start) |-> $past(!cr_busy));
endmodule

// File: rtl/serdes_rx_ovr_seq.sv
module serdes_rx_ovr_seq
  import serdes_ovr_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int GAP_CYC    = 1250,
  parameter int SETTLE_CYC = 750000,
  parameter int POLL_MAX   = 1000,
  localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [LANE_W-1:0] cmd_lane,
  output logic [15:0]       cr_addr,
  output logic [15:0]       cr_wdata,
  input  logic [15:0]       cr_rdata,
  output logic              cr_wr,
  output logic              cr_start,
  input  logic              cr_busy,
  output logic              done
);
  localparam int PW = $clog2(POLL_MAX + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  seq_state_t        st_q, st_d;
  logic              op_q;
  logic [LANE_W-1:0] lane_q;
  logic [15:0]       val_q;
  logic [PW-1:0]     poll_q;
  logic [2:0]        idx_q;
  logic              take_cmd, take_rd, poll_inc, idx_inc, idx_clr;
  logic              req, ack, settle_load, settle_exp;
  logic [15:0]       rdata, req_addr, req_wdata, lane_off;
  logic [15:0]       base_v, en_v, mode_v;

  cr_xact #(.GAP_CYC(GAP_CYC)) u_xact (
    .clk(clk), .rst_n(rst_i_n), .req(req), .req_wr(st_q == S_WRITE),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .cr_addr(cr_addr), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
    .cr_wr(cr_wr), .cr_start(cr_start), .cr_busy(cr_busy)
  );

  dly_timer #(.MAXV(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_i_n), .load(settle_load), .expired(settle_exp)
  );

  // lane addressing and write values
  always_comb begin
    lane_off = 16'({lane_q, 8'h00});
    base_v   = val_q & ~EN_BIT;
    en_v     = base_v | EN_BIT;
    mode_v   = (en_v & ~MODE_FLD) | MODE_SET;
    req      = (st_q == S_READ) || (st_q == S_WRITE);
    req_addr = ((st_q == S_READ) ? STAT_REG : OVR_REG) + lane_off;
    if (!op_q) req_wdata = base_v;
    else begin
      unique case (idx_q)
        3'd0:    req_wdata = base_v;
        3'd1:    req_wdata = en_v;
        3'd3:    req_wdata = mode_v | LRST_BIT;
        default: req_wdata = mode_v;
      endcase
    end
  end

  // next state
  always_comb begin
    st_d = st_q;
    take_cmd = 1'b0; take_rd = 1'b0; poll_inc = 1'b0;
    idx_inc = 1'b0; idx_clr = 1'b0; settle_load = 1'b0;
    unique case (st_q)
      S_IDLE: if (cmd_valid) begin st_d = S_READ; take_cmd = 1'b1; end
      S_READ: if (ack) begin
        take_rd = 1'b1;
        if (!op_q || !rdata[0] || (poll_q == PW'(POLL_MAX - 1))) begin
          st_d = S_WRITE; idx_clr = 1'b1;
        end else poll_inc = 1'b1;
      end
      S_WRITE: if (ack) begin
        if (!op_q) st_d = S_DONE;
        else if (idx_q == 3'(WR_STEPS - 1)) begin
          st_d = S_SETTLE; settle_load = 1'b1;
        end else idx_inc = 1'b1;
      end
      S_SETTLE: if (settle_exp) st_d = S_DONE;
      S_DONE:   st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) st_q <= S_IDLE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      op_q <= 1'b0; lane_q <= '0; val_q <= '0; poll_q <= '0; idx_q <= '0;
    end else begin
      if (take_cmd) begin
        op_q <= cmd_op; lane_q <= cmd_lane; poll_q <= '0;
      end
      if (take_rd)  val_q  <= rdata;
      if (poll_inc) poll_q <= poll_q + 1'b1;
      if (idx_clr)       idx_q <= '0;
      else if (idx_inc)  idx_q <= idx_q + 1'b1;
    end
  end

  assign done = (st_q == S_DONE);

  p_lane_addr_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    cr_start |-> (cr_addr[15:8] == (8'h20 + 8'(lane_q))));
  p_poll_bound_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    poll_q < PW'(POLL_MAX));
  p_settle_hold_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == S_SETTLE && !settle_exp) |=> (st_q == S_SETTLE));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q != S_IDLE && cmd_valid) |=> ($stable(lane_q) && $stable(op_q)));
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == S_IDLE) |-> (!cr_start && !done));
endmodule

// File: tb/sim_serdes_rx_ovr_seq.sv
`timescale 1ns/1ps
module sim_serdes_rx_ovr_seq;
  localparam int GAP = 4, SETTLE = 40, PMAX = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [1:0] cmd_lane = '0;
  logic [15:0] cr_addr, cr_wdata, cr_rdata;
  logic cr_wr, cr_start, cr_busy, done;

  always #10 clk = ~clk;

  serdes_rx_ovr_seq #(.LANES(4), .GAP_CYC(GAP), .SETTLE_CYC(SETTLE),
                      .POLL_MAX(PMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_lane(cmd_lane), .cr_addr(cr_addr), .cr_wdata(cr_wdata),
    .cr_rdata(cr_rdata), .cr_wr(cr_wr), .cr_start(cr_start),
    .cr_busy(cr_busy), .done(done));

  // register-side model
  logic clr = 1'b1;
  logic [15:0] m_stat = '0;
  int m_half = 0;
  int m_rd, n, bcnt, cyc, done_cnt, done_cyc;
  bit viol;
  logic [15:0] l_addr [32];
  logic [15:0] l_data [32];
  logic        l_wr   [32];
  int          l_cyc  [32];
  logic [15:0] rd_q;

  assign cr_busy  = (bcnt != 0);
  assign cr_rdata = rd_q;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bcnt != 0) bcnt <= bcnt - 1;
    if (clr) begin
      n <= 0; m_rd <= 0; done_cnt <= 0; viol <= 1'b0; rd_q <= '0;
    end else begin
      if (cr_start) begin
        if (cr_busy) viol <= 1'b1;
        if (n < 32) begin
          l_addr[n] <= cr_addr; l_data[n] <= cr_wdata;
          l_wr[n] <= cr_wr; l_cyc[n] <= cyc;
        end
        n <= n + 1;
        bcnt <= 3;
        if (!cr_wr) begin
          rd_q <= (m_rd < m_half) ? (m_stat | 16'h1) : (m_stat & ~16'h1);
          m_rd <= m_rd + 1;
        end
      end
      if (done) begin done_cnt <= done_cnt + 1; done_cyc <= cyc; end
    end
  end

  initial begin cyc = 0; bcnt = 0; end

  int tests = 0, fails = 0;
  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // expected transaction list, computed from the requirements
  logic [15:0] e_addr [16];
  logic [15:0] e_data [16];
  logic        e_wr   [16];
  int e_n;
  task automatic build(input bit op, input int lane, input int half,
                       input logic [15:0] stat);
    int reads;
    logic [15:0] last, b, m;
    logic [15:0] off;
    off = 16'(lane * 256);
    reads = op ? ((half + 1 < PMAX) ? half + 1 : PMAX) : 1;
    e_n = 0;
    for (int i = 0; i < reads; i++) begin
      e_addr[e_n] = 16'h2002 + off; e_wr[e_n] = 1'b0; e_data[e_n] = '0; e_n++;
    end
    last = (reads - 1 < half) ? (stat | 16'h1) : (stat & ~16'h1);
    b = last & ~16'h4000;
    m = ((b | 16'h4000) & ~16'h0700) | 16'h0300;
    if (!op) begin
      e_addr[e_n] = 16'h2005 + off; e_wr[e_n] = 1'b1; e_data[e_n] = b; e_n++;
    end else begin
      for (int k = 0; k < 5; k++) begin
        e_addr[e_n] = 16'h2005 + off; e_wr[e_n] = 1'b1;
        e_data[e_n] = (k == 0) ? b : (k == 1) ? (b | 16'h4000) :
                      (k == 3) ? (m | 16'h0800) : m;
        e_n++;
      end
    end
  endtask

  task automatic send(input bit op, input int lane);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_lane = 2'(lane);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int t;
    t = 0; ok = 1'b1;
    while (!done) begin
      @(negedge clk);
      t++;
      if (t > 5000) begin ok = 1'b0; break; end
    end
    repeat (30) @(negedge clk);
  endtask

  task automatic compare(input bit op, input string tag);
    bit ok; int bad;
    chk(n == e_n, op ? "R3" : "R2", {tag, " transaction count"}, n, e_n);
    bad = -1;
    for (int i = 0; i < e_n && i < n; i++) begin
      if (l_addr[i] != e_addr[i] || l_wr[i] != e_wr[i] ||
          (e_wr[i] && l_data[i] != e_data[i])) begin bad = i; break; end
    end
    if (bad >= 0) begin
      if (l_addr[bad] != e_addr[bad])
        chk(1'b0, "R1", {tag, " address"}, l_addr[bad], e_addr[bad]);
      else
        chk(1'b0, op ? "R4" : "R2", {tag, " write value"},
            l_data[bad], e_data[bad]);
    end else chk(1'b1, "R4", tag, 0, 0);
    ok = !viol;
    for (int i = 1; i < n && i < 32; i++)
      if (l_cyc[i] - l_cyc[i-1] < GAP) ok = 1'b0;
    chk(ok, "R6", {tag, " strobe spacing/busy"}, ok, 1);
    chk(done_cnt == 1, "R7", {tag, " done count"}, done_cnt, 1);
    if (op && n > 0)
      chk(done_cyc - l_cyc[n-1] > SETTLE, "R5", {tag, " settle"},
          done_cyc - l_cyc[n-1], SETTLE + 1);
  endtask

  // vector table: {op, lane[1:0], half_reads[3:0], status[15:0]}
  localparam int NV = 7;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 2'd0, 4'd0, 16'h4123},
    {1'b0, 2'd3, 4'd0, 16'hC7FF},
    {1'b1, 2'd1, 4'd0, 16'h4000},
    {1'b1, 2'd2, 4'd2, 16'h0A5C},
    {1'b1, 2'd0, 4'd7, 16'h1235},
    {1'b1, 2'd3, 4'd4, 16'hFFFF},
    {1'b0, 2'd2, 4'd0, 16'h0000}
  };

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    chk(!cr_start && !done, "R9", "outputs in reset", {cr_start, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    clr = 1'b0;
    repeat (20) @(negedge clk);
    chk(n == 0 && done_cnt == 0, "R9", "quiet after reset", n, 0);

    foreach (VEC[v]) begin
      clr = 1'b1;
      m_stat = VEC[v][15:0];
      m_half = int'(VEC[v][19:16]);
      @(negedge clk);
      clr = 1'b0;
      build(VEC[v][22], int'(VEC[v][21:20]), m_half, m_stat);
      send(VEC[v][22], int'(VEC[v][21:20]));
      wait_done(ok);
      chk(ok, "R7", $sformatf("vector %0d done seen", v), ok, 1);
      compare(VEC[v][22], $sformatf("vector %0d", v));
    end

    // R8: a second command while busy is ignored
    clr = 1'b1; m_stat = 16'h1234; m_half = 1;
    @(negedge clk);
    clr = 1'b0;
    build(1'b1, 1, 1, 16'h1234);
    send(1'b1, 1);
    repeat (8) @(negedge clk);
    send(1'b0, 3);
    wait_done(ok);
    chk(ok, "R8", "done after ignored command", ok, 1);
    compare(1'b1, "R8 ignore");
    repeat (50) @(negedge clk);
    chk(n == e_n && done_cnt == 1, "R8", "no work from ignored command",
        n, e_n);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule